// File: doc/BRIEF.md
# Color Channel Sampling Sequencer

This block is the digital control side of a three-color image front end. A bank of eight 9-bit settings registers is loaded through a parallel port with an address, a data word and a write strobe, and any register can be read back combinationally. From the settings it produces a one-hot channel select that tells the analog sampler which color input to take on each pixel clock. It also drives a mode flag and a power-down flag.

In three-channel mode the select steps through the three colors once per pixel-clock enable. It runs either red-green-blue or blue-green-red, chosen by a register bit. An external alignment pulse returns the rotation to the first color of the chosen order. In single-channel mode the select stays on one color, picked by one of three bits in the channel register. A power-down request forces the select low and freezes the rotation. The registers keep their contents and still take writes while powered down.

Top module: `chan_seq_top`

## Requirements
- R1: After a synchronous active-low reset, address 0 (setup) reads 0x0F8, address 1 (channel) reads 0x0C0 and addresses 2 to 7 read 0x000. The select reads red and the flags read three-channel on, power-down off.
- R2: A write with the strobe high stores the 9-bit data at the given address from the next clock edge. The gain and offset registers (addresses 2 to 7) keep all nine bits.
- R3: Reserved bits are cleared on write and always read zero. In the setup register these are bits 8, 1 and 0. In the channel register they are bits 8 and 3 to 0.
- R4: With setup bit 5 high, channel bit 7 high and power-down clear, each cycle with the pixel enable high moves the select one step through red, green, blue and back to red. A cycle without the enable leaves it unchanged.
- R5: With channel bit 7 low, the rotation order is blue, green, red.
- R6: An alignment pulse in three-channel mode makes the select show the first color of the current order (red, or blue when bit 7 is low) after that edge. It wins over a pixel enable in the same cycle.
- R7: With setup bit 5 low, the select stays on the color chosen by channel bits 6 (red), 5 (green) and 4 (blue). Pixel enables and alignment pulses do not change it.
- R8: In single-channel mode, if several color bits are set, red wins over green and green wins over blue. If none is set, the select is all zero. The select is never more than one-hot.
- R9: While setup bit 2 (power-down) is high, the select is zero and pixel enables do not move the rotation. When power-down clears, the rotation resumes from the color it held before. Writes are still accepted, and stored values are kept.
- R10: The mode flag follows setup bit 5 and the power-down flag follows setup bit 2, both from the edge on which the write lands.
- Select encoding: bit 2 is red, bit 1 is green, bit 0 is blue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address for writes |
| wr_data | input | 9 | Register write data |
| rd_addr | input | 3 | Register address for read-back |
| rd_data | output | 9 | Read-back data, combinational from rd_addr |
| pix_en | input | 1 | Pixel-clock enable, advances the rotation |
| align_pulse | input | 1 | Re-alignment pulse, returns the rotation to its first color |
| sel_out | output | 3 | One-hot color select: bit 2 red, bit 1 green, bit 0 blue |
| three_ch_mode | output | 1 | High in three-channel mode |
| power_down | output | 1 | High while power-down is requested |

## Verification
Every result of this block lands on the clock edge that takes the stimulus. The only state is the register bank and the rotation position, and the select, flags and read-back are all combinational from that state. So a write, a pixel enable or an alignment pulse presented in one cycle shows on the outputs in the half-cycle after the next rising edge, which is zero cycles of added latency. The driver raises each stimulus just after a rising edge and drops it just after the following one. It then queues the expected value, and the monitor compares it on the next falling edge, when the outputs have settled and no input is moving.

// File: rtl/chan_seq_pkg.sv
// Package: shared widths, register addresses, field positions, reset values
// and write masks for the color channel sampling sequencer.
// Assumes an 8-entry bank of 9-bit registers.
package chan_seq_pkg;

    parameter int DATA_W     = 9;
    parameter int ADDR_W     = 3;
    parameter int NUM_REGS   = 1 << ADDR_W;
    parameter int NUM_COLORS = 3;
    parameter int POS_W      = $clog2(NUM_COLORS);

    // Register addresses whose contents the sequencer decodes
    parameter logic [ADDR_W-1:0] ADDR_SETUP = 3'd0;
    parameter logic [ADDR_W-1:0] ADDR_CHAN  = 3'd1;

    // Setup register field positions
    parameter int SETUP_THREE_CH = 5;
    parameter int SETUP_PWR_DN   = 2;

    // Channel register field positions
    parameter int CHAN_ORDER_RGB = 7;
    parameter int CHAN_PICK_RED  = 6;
    parameter int CHAN_PICK_GRN  = 5;
    parameter int CHAN_PICK_BLU  = 4;

    // Select bit positions
    parameter int SEL_RED = 2;
    parameter int SEL_GRN = 1;
    parameter int SEL_BLU = 0;

    // Writable-bit masks: reserved positions are zero
    parameter logic [DATA_W-1:0] SETUP_WMASK = 9'h0FC;
    parameter logic [DATA_W-1:0] CHAN_WMASK  = 9'h0F0;
    parameter logic [DATA_W-1:0] FULL_WMASK  = 9'h1FF;

    // Reset values
    parameter logic [DATA_W-1:0] SETUP_RST = 9'h0F8;
    parameter logic [DATA_W-1:0] CHAN_RST  = 9'h0C0;

    typedef enum logic [2:0] {
        COL_NONE = 3'b000,
        COL_BLU  = 3'b001,
        COL_GRN  = 3'b010,
        COL_RED  = 3'b100
    } color_t;

    // Writable mask for a given register address
    function automatic logic [DATA_W-1:0] wmask_of(input int idx);
        if (idx == int'(ADDR_SETUP)) return SETUP_WMASK;
        if (idx == int'(ADDR_CHAN))  return CHAN_WMASK;
        return FULL_WMASK;
    endfunction

    // Reset value for a given register address
    function automatic logic [DATA_W-1:0] rst_of(input int idx);
        if (idx == int'(ADDR_SETUP)) return SETUP_RST;
        if (idx == int'(ADDR_CHAN))  return CHAN_RST;
        return '0;
    endfunction

endpackage

// File: rtl/csq_regbank.sv
// Register bank: NUM_REGS words of DATA_W bits, written on a strobe, read
// combinationally. Reserved bits are masked on write and reset per address.
// Assumes a single write port; writes are accepted in every power state.
module csq_regbank
    import chan_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] setup_q,
    output logic [DATA_W-1:0] chan_q
);

    logic [DATA_W-1:0] regs_q [NUM_REGS];

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        localparam logic [DATA_W-1:0] WMASK = wmask_of(gi);
        localparam logic [DATA_W-1:0] RSTV  = rst_of(gi);

        // Load one word on a matching write; restore its reset value on reset
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[gi] <= RSTV;
            else if (wr_en && (wr_addr == ADDR_W'(gi)))
                regs_q[gi] <= wr_data & WMASK;
        end
    end

    // Read-back multiplexer and decoded register taps
    always_comb begin
        rd_data = regs_q[rd_addr];
        setup_q = regs_q[ADDR_SETUP];
        chan_q  = regs_q[ADDR_CHAN];
    end

endmodule

// File: rtl/csq_rotator.sv
// Rotation position counter: steps 0..NUM_COLORS-1 on each enable while
// running, wraps, and returns to 0 on an alignment pulse (which wins).
// Assumes run is low in single-channel mode and in power-down, so the
// position is frozen then.
module csq_rotator
    import chan_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic             align,
    output logic [POS_W-1:0] pos
);

    localparam logic [POS_W-1:0] LAST = POS_W'(NUM_COLORS - 1);

    logic [POS_W-1:0] pos_q;

    // Advance, wrap or re-align the position
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_q <= '0;
        else if (run && align)
            pos_q <= '0;
        else if (run && step)
            pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
    end

    assign pos = pos_q;

endmodule

// File: rtl/csq_select.sv
// Select decoder: turns the rotation position and the channel register
// into a one-hot color select. It applies the order bit in three-channel
// mode and the red > green > blue priority in single-channel mode, and
// forces zero in power-down.
module csq_select
    import chan_seq_pkg::*;
(
    input  logic [POS_W-1:0]  pos,
    input  logic [DATA_W-1:0] chan_q,
    input  logic              three_ch,
    input  logic              pwr_dn,
    output logic [2:0]        sel
);

    color_t rot_col;
    color_t fix_col;

    // Map the rotation position onto a color for the chosen order
    always_comb begin
        unique case (pos)
            POS_W'(0): rot_col = chan_q[CHAN_ORDER_RGB] ? COL_RED : COL_BLU;
            POS_W'(1): rot_col = COL_GRN;
            POS_W'(2): rot_col = chan_q[CHAN_ORDER_RGB] ? COL_BLU : COL_RED;
            default:   rot_col = COL_NONE;
        endcase
    end

    // Priority pick of the fixed color in single-channel mode
    always_comb begin
        if (chan_q[CHAN_PICK_RED])      fix_col = COL_RED;
        else if (chan_q[CHAN_PICK_GRN]) fix_col = COL_GRN;
        else if (chan_q[CHAN_PICK_BLU]) fix_col = COL_BLU;
        else                            fix_col = COL_NONE;
    end

    // Final select with power-down gating
    always_comb begin
        if (pwr_dn)        sel = COL_NONE;
        else if (three_ch) sel = rot_col;
        else               sel = fix_col;
    end

endmodule

// File: rtl/chan_seq_top.sv
// Color channel sampling sequencer top. It joins the register bank, the
// rotation counter and the select decoder. All outputs are combinational
// from registered state, so each stimulus shows up after the edge that
// takes it.
module chan_seq_top
    import chan_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              pix_en,
    input  logic              align_pulse,
    output logic [2:0]        sel_out,
    output logic              three_ch_mode,
    output logic              power_down
);

    logic [DATA_W-1:0] setup_q;
    logic [DATA_W-1:0] chan_q;
    logic [POS_W-1:0]  pos;
    logic              run;
    logic              rgb_order;

    csq_regbank u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .setup_q (setup_q),
        .chan_q  (chan_q)
    );

    // Mode decode from the setup and channel registers
    always_comb begin
        three_ch_mode = setup_q[SETUP_THREE_CH];
        power_down    = setup_q[SETUP_PWR_DN];
        rgb_order     = chan_q[CHAN_ORDER_RGB];
        run           = three_ch_mode && !power_down;
    end

    csq_rotator u_rot (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .step  (pix_en),
        .align (align_pulse),
        .pos   (pos)
    );

    csq_select u_sel (
        .pos      (pos),
        .chan_q   (chan_q),
        .three_ch (three_ch_mode),
        .pwr_dn   (power_down),
        .sel      (sel_out)
    );

endmodule

// File: rtl/csq_checker.sv
// Property checker for chan_seq_top, attached by bind. It watches ports and
// the decoded order bit and flags any break of the select rules.
module csq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       pix_en,
    input logic       align_pulse,
    input logic [2:0] rd_addr,
    input logic [8:0] rd_data,
    input logic [2:0] sel_out,
    input logic       three_ch_mode,
    input logic       power_down,
    input logic       rgb_order
);

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_out)); // R8

    AST_PD_SEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |-> (sel_out == 3'b000)); // R9

    AST_ALIGN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (align_pulse && three_ch_mode && !power_down && !wr_en)
        |=> (sel_out == (rgb_order ? 3'b100 : 3'b001))); // R6

    AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && !align_pulse && three_ch_mode && !power_down && !wr_en)
        |=> (sel_out != $past(sel_out))); // R4

    AST_SINGLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!three_ch_mode && !power_down && !wr_en) |=> $stable(sel_out)); // R7

    AST_CHAN_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 3'd1) |-> (rd_data[8] == 1'b0 && rd_data[3:0] == 4'h0)); // R3

    AST_SETUP_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 3'd0) |-> (rd_data[8] == 1'b0 && rd_data[1:0] == 2'b00)); // R3

endmodule

bind chan_seq_top csq_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .pix_en        (pix_en),
    .align_pulse   (align_pulse),
    .rd_addr       (rd_addr),
    .rd_data       (rd_data),
    .sel_out       (sel_out),
    .three_ch_mode (three_ch_mode),
    .power_down    (power_down),
    .rgb_order     (rgb_order)
);

// File: tb/chan_seq_top_tb.sv
// Scoreboard bench for chan_seq_top. Driver tasks apply stimulus just after
// a rising edge and queue the expected result; a monitor pops and compares
// on the following falling edge.
module chan_seq_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [8:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [8:0] rd_data;
    logic       pix_en = 1'b0;
    logic       align_pulse = 1'b0;
    logic [2:0] sel_out;
    logic       three_ch_mode;
    logic       power_down;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    typedef enum int { K_SEL, K_RD, K_FLAGS } kind_t;
    typedef struct {
        kind_t      kind;
        logic [8:0] exp;
        string      req;
    } item_t;

    item_t sb_q[$];

    always #5 clk = ~clk;

    chan_seq_top dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .rd_addr       (rd_addr),
        .rd_data       (rd_data),
        .pix_en        (pix_en),
        .align_pulse   (align_pulse),
        .sel_out       (sel_out),
        .three_ch_mode (three_ch_mode),
        .power_down    (power_down)
    );

    // Monitor: pop one expected item per falling edge and compare
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            logic [8:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                K_SEL:   act = {6'd0, sel_out};
                K_RD:    act = rd_data;
                default: act = {7'd0, three_ch_mode, power_down};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_err++;
                $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
            end
        end
    end

    task automatic tick(input logic pix, input logic aln);
        pix_en = pix; align_pulse = aln;
        @(posedge clk); #1;
        pix_en = 1'b0; align_pulse = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [8:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic push_wait(input kind_t k, input logic [8:0] e, input string r);
        item_t it;
        it.kind = k; it.exp = e; it.req = r;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic chk_sel(input logic [2:0] e, input string r);
        push_wait(K_SEL, {6'd0, e}, r);
    endtask

    task automatic chk_rd(input logic [2:0] a, input logic [8:0] e, input string r);
        rd_addr = a;
        push_wait(K_RD, e, r);
    endtask

    task automatic chk_flags(input logic m, input logic p, input string r);
        push_wait(K_FLAGS, {7'd0, m, p}, r);
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // Stimulus sequence
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        for (int a = 0; a < 8; a++)
            chk_rd(3'(a), (a == 0) ? 9'h0F8 : (a == 1) ? 9'h0C0 : 9'h000, "R1");
        chk_sel(3'b100, "R1");
        chk_flags(1'b1, 1'b0, "R1");

        // R2 full-width gain/offset
        wr(3'd2, 9'h1A5); chk_rd(3'd2, 9'h1A5, "R2");
        wr(3'd7, 9'h15A); chk_rd(3'd7, 9'h15A, "R2");

        // R3 reserved bits masked
        wr(3'd0, 9'h1FF); chk_rd(3'd0, 9'h0FC, "R3");
        wr(3'd0, 9'h0F8);
        wr(3'd1, 9'h1FF); chk_rd(3'd1, 9'h0F0, "R3");
        wr(3'd1, 9'h0C0);

        // R4 rotation R-G-B
        chk_sel(3'b100, "R4");
        tick(1, 0); chk_sel(3'b010, "R4");
        tick(1, 0); chk_sel(3'b001, "R4");
        tick(1, 0); chk_sel(3'b100, "R4");
        tick(0, 0); chk_sel(3'b100, "R4");

        // R6 alignment in R-G-B
        tick(1, 0); chk_sel(3'b010, "R6");
        tick(0, 1); chk_sel(3'b100, "R6");
        tick(1, 0); chk_sel(3'b010, "R6");
        tick(1, 1); chk_sel(3'b100, "R6");

        // R5 rotation B-G-R
        wr(3'd1, 9'h040); chk_sel(3'b001, "R5");
        tick(1, 0); chk_sel(3'b010, "R5");
        tick(1, 0); chk_sel(3'b100, "R5");
        tick(1, 0); chk_sel(3'b001, "R5");
        tick(1, 0); tick(0, 1); chk_sel(3'b001, "R6");

        // R9 power-down
        tick(1, 0); chk_sel(3'b010, "R9");
        wr(3'd0, 9'h0FC); chk_sel(3'b000, "R9");
        chk_flags(1'b1, 1'b1, "R10");
        tick(1, 0); tick(1, 0); chk_sel(3'b000, "R9");
        wr(3'd3, 9'h0AA); chk_rd(3'd3, 9'h0AA, "R9");
        chk_rd(3'd2, 9'h1A5, "R9");
        wr(3'd0, 9'h0F8); chk_sel(3'b010, "R9");
        chk_flags(1'b1, 1'b0, "R10");

        // R7 single-channel mode
        wr(3'd0, 9'h0D8); chk_flags(1'b0, 1'b0, "R10");
        chk_sel(3'b100, "R7");
        tick(1, 0); chk_sel(3'b100, "R7");
        tick(0, 1); chk_sel(3'b100, "R7");
        wr(3'd1, 9'h0A0); chk_sel(3'b010, "R7");
        tick(1, 0); chk_sel(3'b010, "R7");
        wr(3'd1, 9'h010); chk_sel(3'b001, "R7");

        // R8 priority and none
        wr(3'd1, 9'h070); chk_sel(3'b100, "R8");
        wr(3'd1, 9'h030); chk_sel(3'b010, "R8");
        wr(3'd1, 9'h000); chk_sel(3'b000, "R8");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule